// File: doc/BRIEF.md
# Half-Bridge PWM Driver with Dead-Band and Fault Shutdown

This block turns one base PWM waveform into a complementary pair of gate drives for a half-bridge. Output A follows the base PWM and output B follows its inverse. Each output is switched on only after a programmable dead-band has elapsed, which leaves time for the opposite switch to turn off first. Every output is switched off with no delay. The dead-band is counted in ticks that are four clock periods long, with a 7-bit count.

Three shutdown sources are monitored: two comparator outputs (active high) and a fault pin (active low). A select field enables any mix of them. While an enabled source is active, both outputs go at once, with no clock edge, to a configured shutdown level: drive low, drive high or released (output-enable low). A status flag records the event. It clears by itself when restart is enabled, or it waits for a software clear. A clear is refused while a source is still active. Normal drive returns only at a period-start strobe that arrives while the flag is already clear. The period/duty timer that produces the base PWM and the strobe sits outside this block. Register values enter as plain ports.

Top module: `hb_pwm_guard`

## Requirements
- R1: While not in shutdown, oe_a and oe_b are 1, pin_a tracks pwm_in, pin_b tracks its inverse (each subject to R2), and pin_a and pin_b are never both 1.
- R2: An output is switched on exactly 4*dead_cnt clock cycles after the first rising clock edge at which its request (pwm_in for A, ~pwm_in for B) is sampled high. With dead_cnt = 0 it is switched on in the same cycle as the request.
- R3: An output switches off in the same cycle its request goes low, with no dead-band.
- R4: If the request drops before the dead-band expires, the output is never switched on, and a new request starts a full new count.
- R5: src_sel bit 0 enables cmp1 (active high), bit 1 enables cmp2 (active high) and bit 2 enables fault_n (active low). With src_sel = 000 no input causes a shutdown.
- R6: While an enabled source is active, the outputs take their shutdown levels combinationally, in the same cycle. lvl_a controls A and lvl_b controls B: 00 = pin 0 with oe 1, 01 = pin 1 with oe 1, 1x = pin 0 with oe 0.
- R7: sd_flag is 1 after any clock edge at which an enabled source is active. With auto_restart = 1 it returns to 0 at the first edge at which no enabled source is active.
- R8: With auto_restart = 0, sd_flag stays 1 until a sw_clr pulse is sampled while no enabled source is active. A sw_clr while a source is active has no effect.
- R9: After a shutdown, the outputs keep their shutdown levels until a period_start pulse is sampled while sd_flag is 0. A period_start seen while sd_flag is 1 keeps the shutdown levels for that whole period.
- R10: After reset, sd_flag is 0, both oe outputs are 1 and no shutdown is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Base PWM waveform from the period/duty timer |
| period_start | input | 1 | One-cycle strobe at each PWM period boundary |
| dead_cnt | input | 7 | Dead-band length in ticks of four clocks |
| src_sel | input | 3 | Shutdown source enables {fault, cmp2, cmp1} |
| auto_restart | input | 1 | 1 = flag clears by itself once sources go inactive |
| sw_clr | input | 1 | Software clear request for the shutdown flag |
| cmp1 | input | 1 | Comparator 1 output, active high |
| cmp2 | input | 1 | Comparator 2 output, active high |
| fault_n | input | 1 | Fault pin, active low |
| lvl_a | input | 2 | Shutdown level for output A |
| lvl_b | input | 2 | Shutdown level for output B |
| pin_a | output | 1 | Gate drive A value |
| oe_a | output | 1 | Gate drive A output enable |
| pin_b | output | 1 | Gate drive B value |
| oe_b | output | 1 | Gate drive B output enable |
| sd_flag | output | 1 | Shutdown status flag |

## Verification
The bench uses the default parameters: a 7-bit dead-band count and a tick divider of four. With these values a dead-band of 3 takes 12 cycles, so the bench can sample the cycle just before switch-on and the cycle of switch-on exactly. It can also drop a request halfway through a count. The short count keeps the shutdown-flag and period-gating sequences within a few dozen cycles, and the zero-count case puts the combinational switch-on path within reach.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

  localparam int SRC_N = 3;

  // Shutdown level code: bit 1 set releases the pin, otherwise bit 0 is the driven value.
  typedef logic [1:0] sd_lvl_t;

  // Any enabled source active: {fault (low), cmp2, cmp1}.
  function automatic logic src_trip(input logic [SRC_N-1:0] sel,
                                    input logic c1, input logic c2, input logic fn);
    return |(sel & {~fn, c2, c1});
  endfunction

  // Returns {pin, oe} for one gate output.
  function automatic logic [1:0] pin_drive(input sd_lvl_t lvl, input logic forced,
                                           input logic act);
    if (!forced) return {act, 1'b1};
    if (lvl[1]) return 2'b00;
    return {lvl[0], 1'b1};
  endfunction

endpackage

// File: rtl/hbp_tick.sv
module hbp_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ph_q <= '0;
    else if (clr || ph_q == LAST) ph_q <= '0;
    else                        ph_q <= ph_q + 1'b1;
  end

  assign tick = (ph_q == LAST);

  // R2: a tick lasts one clock when the divider is wider than one
  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && DIV > 1) |=> !tick);
endmodule

// File: rtl/hbp_deadband.sv
module hbp_deadband #(
  parameter int DLY_W = 7,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [DLY_W-1:0] dly,
  output logic             act
);
  logic             req_q;
  logic [DLY_W-1:0] cnt_q;
  logic             start_w;
  logic             tick_w;

  function automatic logic [DLY_W-1:0] count_next(input logic r, input logic s,
      input logic t, input logic [DLY_W-1:0] c, input logic [DLY_W-1:0] d);
    if (!r) return '0;
    if (s) return d;
    if (t && c != '0) return c - 1'b1;
    return c;
  endfunction

  assign start_w = req & ~req_q;

  hbp_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_w | ~req),
    .tick (tick_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req;
      cnt_q <= count_next(req, start_w, tick_w, cnt_q, dly);
    end
  end

  assign act = req & (start_w ? (dly == '0) : (cnt_q == '0));

  // R2: a nonzero delay keeps the output off after the request edge
  p_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && dly != '0) |=> !act);
  // R4: never on while a count is pending
  p_pending_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> !act);
  // R3: a dropped request turns the output off at once
  p_fast_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !req) |-> !act);
endmodule

// File: rtl/hbp_shutdown.sv
module hbp_shutdown (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  input  logic auto_rs,
  input  logic sw_clr,
  input  logic period_start,
  output logic flag,
  output logic forced
);
  logic flag_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (trip)         flag_q <= 1'b1;
      else if (auto_rs) flag_q <= 1'b0;
      else if (sw_clr)  flag_q <= 1'b0;

      if (trip)              hold_q <= 1'b1;
      else if (period_start) hold_q <= flag_q;
    end
  end

  assign flag   = flag_q;
  assign forced = trip | hold_q;

  // R7: an active source sets the flag
  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> flag_q);
  // R7: automatic restart clears once sources are gone
  p_auto_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && auto_rs && !trip) |=> !flag_q);
  // R8: without restart or clear the flag sticks
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !auto_rs && !sw_clr) |=> flag_q);
  // R8: a clear during an active source is refused
  p_clr_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && sw_clr) |=> flag_q);
  // R9: release only at a period start
  p_hold_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !period_start) |=> hold_q);
  // R9: a period that starts with the flag set stays in shutdown
  p_period_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && flag_q) |=> forced);
endmodule

// File: rtl/hb_pwm_guard.sv
module hb_pwm_guard #(
  parameter int DLY_W = 7,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             period_start,
  input  logic [DLY_W-1:0] dead_cnt,
  input  logic [2:0]       src_sel,
  input  logic             auto_restart,
  input  logic             sw_clr,
  input  logic             cmp1,
  input  logic             cmp2,
  input  logic             fault_n,
  input  logic [1:0]       lvl_a,
  input  logic [1:0]       lvl_b,
  output logic             pin_a,
  output logic             oe_a,
  output logic             pin_b,
  output logic             oe_b,
  output logic             sd_flag
);
  import hbp_pkg::*;

  localparam int CH_N = 2;

  logic [CH_N-1:0] req_w;
  logic [CH_N-1:0] act_w;
  logic            trip_w;
  logic            forced_w;
  logic [1:0]      drv_a;
  logic [1:0]      drv_b;

  assign trip_w = src_trip(src_sel, cmp1, cmp2, fault_n);

  for (genvar gi = 0; gi < CH_N; gi++) begin : g_ch
    if (gi == 0) begin : g_hi
      assign req_w[gi] = pwm_in;
    end else begin : g_lo
      assign req_w[gi] = ~pwm_in;
    end
    hbp_deadband #(.DLY_W(DLY_W), .DIV(DIV)) u_db (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_w[gi]),
      .dly  (dead_cnt),
      .act  (act_w[gi])
    );
  end

  hbp_shutdown u_sd (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip        (trip_w),
    .auto_rs     (auto_restart),
    .sw_clr      (sw_clr),
    .period_start(period_start),
    .flag        (sd_flag),
    .forced      (forced_w)
  );

  assign drv_a = pin_drive(lvl_a, forced_w, act_w[0]);
  assign drv_b = pin_drive(lvl_b, forced_w, act_w[1]);
  assign {pin_a, oe_a} = drv_a;
  assign {pin_b, oe_b} = drv_b;

  // R1: complementary drives never overlap in normal operation
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !forced_w |-> !(pin_a && pin_b));
  // R5: an empty select never trips
  p_empty_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b000) |-> !trip_w);
  // R6: a released level drops the output enable
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (forced_w && lvl_a[1]) |-> (!oe_a && !pin_a));
endmodule

// File: tb/hb_pwm_guard_test.sv
module hb_pwm_guard_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0, period_start = 1'b0, auto_restart = 1'b0, sw_clr = 1'b0;
  logic [6:0] dead_cnt = '0;
  logic [2:0] src_sel = '0;
  logic       cmp1 = 1'b0, cmp2 = 1'b0, fault_n = 1'b1;
  logic [1:0] lvl_a = '0, lvl_b = '0;
  logic       pin_a, oe_a, pin_b, oe_b, sd_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hb_pwm_guard uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
    .dead_cnt(dead_cnt), .src_sel(src_sel), .auto_restart(auto_restart),
    .sw_clr(sw_clr), .cmp1(cmp1), .cmp2(cmp2), .fault_n(fault_n),
    .lvl_a(lvl_a), .lvl_b(lvl_b), .pin_a(pin_a), .oe_a(oe_a),
    .pin_b(pin_b), .oe_b(oe_b), .sd_flag(sd_flag)
  );

  // {sel[3], cmp1, cmp2, fault_n, lvl_a[2], lvl_b[2], pin_a, oe_a, pin_b, oe_b}
  localparam logic [13:0] VEC [8] = '{
    14'b000_1_1_0_01_01_1101,   // R5 nothing selected
    14'b001_1_0_1_00_01_0111,   // R5 cmp1, R6 low/high
    14'b001_0_1_0_00_01_1101,   // R5 unselected sources
    14'b010_0_1_1_10_01_0011,   // R5 cmp2, R6 release
    14'b100_0_0_0_11_10_0000,   // R5 fault low, R6 release both
    14'b100_1_1_1_00_00_1101,   // R5 fault high idle
    14'b111_0_1_1_00_00_0101,   // R5 any of all
    14'b110_1_0_1_01_01_1101    // R5 cmp1 not selected
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_ps();
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
  endtask

  initial begin
    // R10 reset state
    pwm_in = 1'b0; dead_cnt = 7'd3;
    do_reset();
    #2;
    chk("R10 flag/oe", {1'b0, sd_flag, oe_a, oe_b}, 4'b0011);

    // table walk: combinational shutdown levels
    for (int i = 0; i < 8; i++) begin
      src_sel = '0; cmp1 = 0; cmp2 = 0; fault_n = 1; pwm_in = 1; dead_cnt = '0;
      do_reset();
      repeat (2) @(negedge clk);
      {src_sel, cmp1, cmp2, fault_n, lvl_a, lvl_b} = VEC[i][13:4];
      #2;
      chk("R6 vector", {pin_a, oe_a, pin_b, oe_b}, VEC[i][3:0]);
    end
    src_sel = '0; cmp1 = 0; cmp2 = 0; fault_n = 1;
    do_reset();

    // R1 complementary steady states
    dead_cnt = 7'd3; pwm_in = 1'b0;
    repeat (20) @(negedge clk);
    #2 chk("R1 low", {pin_a, oe_a, pin_b, oe_b}, 4'b0111);
    // R2 exact delay, R3 immediate off
    @(negedge clk); pwm_in = 1'b1;
    #2 chk("R3 off", {2'b00, pin_a, pin_b}, 4'b0000);
    repeat (12) @(posedge clk);
    #2 chk("R2 before", {3'b000, pin_a}, 4'b0000);
    @(posedge clk);
    #2 chk("R2 on", {3'b000, pin_a}, 4'b0001);
    chk("R1 high", {pin_a, oe_a, pin_b, oe_b}, 4'b1101);

    // R2 zero delay: switch-on in the same cycle
    dead_cnt = 7'd0;
    @(negedge clk); pwm_in = 1'b0;
    #2 chk("R2 zero", {2'b00, pin_a, pin_b}, 4'b0001);

    // R4 short request never switches on, new request counts afresh
    dead_cnt = 7'd3;
    @(negedge clk); pwm_in = 1'b1;
    begin
      logic seen = 1'b0;
      for (int k = 0; k < 6; k++) begin
        @(posedge clk); #2; seen |= pin_a;
      end
      @(negedge clk); pwm_in = 1'b0;
      #2 seen |= pin_a;
      chk("R4 aborted", {3'b000, seen}, 4'b0000);
    end
    @(negedge clk); pwm_in = 1'b1;
    repeat (12) @(posedge clk);
    #2 chk("R4 restart before", {3'b000, pin_a}, 4'b0000);
    @(posedge clk);
    #2 chk("R4 restart on", {3'b000, pin_a}, 4'b0001);

    // R7 automatic restart, R9 gated release
    dead_cnt = '0; lvl_a = 2'b00; lvl_b = 2'b01; src_sel = 3'b001; auto_restart = 1'b1;
    @(negedge clk); cmp1 = 1'b1;
    #2 chk("R6 forced", {pin_a, oe_a, pin_b, oe_b}, 4'b0111);
    @(posedge clk);
    #2 chk("R7 set", {3'b000, sd_flag}, 4'b0001);
    @(negedge clk); cmp1 = 1'b0;
    #2 chk("R9 held", {pin_a, oe_a, pin_b, oe_b}, 4'b0111);
    @(posedge clk);
    #2 chk("R7 auto clear", {3'b000, sd_flag}, 4'b0000);
    repeat (3) @(posedge clk);
    #2 chk("R9 until period", {3'b000, pin_a}, 4'b0000);
    pulse_ps();
    #2 chk("R9 release", {pin_a, oe_a, pin_b, oe_b}, 4'b1101);

    // R8 manual restart
    auto_restart = 1'b0;
    @(negedge clk); cmp1 = 1'b1;
    @(negedge clk); sw_clr = 1'b1;
    @(negedge clk); sw_clr = 1'b0; cmp1 = 1'b0;
    #2 chk("R8 clear refused", {3'b000, sd_flag}, 4'b0001);
    repeat (4) @(negedge clk);
    #2 chk("R8 sticky", {3'b000, sd_flag}, 4'b0001);
    pulse_ps();
    #2 chk("R9 period with flag", {3'b000, pin_a}, 4'b0000);
    @(negedge clk); sw_clr = 1'b1;
    @(negedge clk); sw_clr = 1'b0;
    #2 chk("R8 cleared", {3'b000, sd_flag}, 4'b0000);
    chk("R9 still held", {3'b000, pin_a}, 4'b0000);
    pulse_ps();
    #2 chk("R9 resumed", {pin_a, oe_a, pin_b, oe_b}, 4'b1101);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule